// File: doc/BRIEF.md
# Tournament Branch Predictor

This block predicts the direction of conditional branches. A stream of branch identifiers drives it, each paired with the outcome that branch actually took, and no instruction address is involved. It runs two predictors side by side. The global predictor keeps a short shift register of the most recent outcomes of all branches. For the presented branch, that history selects one of several saturating counters. The local predictor keeps, for each branch, the single last outcome of that branch. That bit selects one of two counters belonging to that branch. A per-branch saturating selector decides which of the two predictions becomes the final one.

Each cycle with `in_valid` high, the block shows four values combinationally from its current state: the global prediction, the local prediction, the selector choice and the final prediction. On the following clock edge it trains both counters, shifts the outcome into the history, records the branch's last outcome, moves the selector and counts a miss if the final prediction was wrong. The running miss count lets different branch traces be compared directly.

Top module: `tourney_pred`

## Requirements
- R1: After reset, with default parameters, the miss count is 0. Every prediction counter holds 01, every selector holds 01, the history is 00 and each branch's last outcome is not-taken, so all four prediction outputs read 0.
- R2: Every prediction counter is 2 bits wide and predicts taken when its MSB is 1. A taken outcome raises it by one and a not-taken outcome lowers it by one. It stops at 3 and at 0 and never wraps.
- R3: The global counter used is the one at column {in_id, history} in the global table. The history is 2 bits wide, and after each valid pair it becomes {history[0], outcome}.
- R4: The local counter used is the one at column {in_id, last outcome of in_id}. After each valid pair, the last outcome of that branch becomes the actual outcome.
- R5: Each branch's 2-bit selector chooses local when its MSB is 1. It changes only when the global and local predictions differ. It then moves one step toward local if the local prediction matched the outcome, and one step toward global otherwise, stopping at 0 and 3.
- R6: The final prediction equals the local prediction when `sel_local` is 1 and the global prediction when it is 0.
- R7: The miss count rises by exactly one on each valid cycle where the final prediction differs from the outcome, and holds otherwise.
- R8: A cycle with `in_valid` low changes no state. The outputs for any later pair match a history in which that cycle never happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A branch/outcome pair is presented |
| in_id | input | ID_W (3) | Branch identifier |
| in_taken | input | 1 | Actual outcome, 1 = taken |
| glob_pred | output | 1 | Global predictor's direction for in_id |
| loc_pred | output | 1 | Local predictor's direction for in_id |
| sel_local | output | 1 | Selector choice, 1 = local |
| final_pred | output | 1 | Tournament prediction |
| miss_count | output | MISS_W (16) | Running misprediction count |

## Verification
The assertions rely on two assumptions: `in_id` and `in_taken` are settled for the whole cycle in which `in_valid` is high, and the miss count never passes its maximum. The idle-hold property also assumes that an identifier held across an idle cycle addresses the same entries. The stimulus changes inputs only at the falling edge and sends a few hundred pairs, far below the 16-bit limit. It mixes loop-like, alternating, saturating and pseudo-random traces across all eight identifiers, with idle cycles placed between them.

// File: rtl/tourney_pred.sv
module tourney_pred #(
  parameter int NUM_BR = 8,
  parameter int HIST_W = 2,
  parameter int CNT_W = 2,
  parameter int SEL_W = 2,
  parameter int MISS_W = 16,
  parameter logic [CNT_W-1:0] CNT_INIT = 2'b01,
  parameter logic [SEL_W-1:0] SEL_INIT = 2'b01,
  localparam int ID_W = $clog2(NUM_BR),
  localparam int GDEPTH = NUM_BR << HIST_W,
  localparam int LDEPTH = NUM_BR * 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ID_W-1:0]   in_id,
  input  logic              in_taken,
  output logic              glob_pred,
  output logic              loc_pred,
  output logic              sel_local,
  output logic              final_pred,
  output logic [MISS_W-1:0] miss_count
);

  logic [CNT_W-1:0]  gtab [GDEPTH];
  logic [CNT_W-1:0]  ltab [LDEPTH];
  logic [SEL_W-1:0]  sel_q [NUM_BR];
  logic [NUM_BR-1:0] last_q;
  logic [HIST_W-1:0] hist_q;

  logic [ID_W+HIST_W-1:0] gidx;
  logic [ID_W:0]          lidx;

  assign gidx       = {in_id, hist_q};
  assign lidx       = {in_id, last_q[in_id]};
  assign glob_pred  = gtab[gidx][CNT_W-1];
  assign loc_pred   = ltab[lidx][CNT_W-1];
  assign sel_local  = sel_q[in_id][SEL_W-1];
  assign final_pred = sel_local ? loc_pred : glob_pred;

  function automatic logic [CNT_W-1:0] bump_c(input logic [CNT_W-1:0] c, input logic up);
    if (up) return (&c) ? c : c + 1'b1;
    return (|c) ? c - 1'b1 : c;
  endfunction

  function automatic logic [SEL_W-1:0] bump_s(input logic [SEL_W-1:0] s, input logic up);
    if (up) return (&s) ? s : s + 1'b1;
    return (|s) ? s - 1'b1 : s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < GDEPTH; i++) gtab[i] <= CNT_INIT;
      for (int i = 0; i < LDEPTH; i++) ltab[i] <= CNT_INIT;
      for (int i = 0; i < NUM_BR; i++) sel_q[i] <= SEL_INIT;
      last_q     <= '0;
      hist_q     <= '0;
      miss_count <= '0;
    end else if (in_valid) begin
      gtab[gidx]    <= bump_c(gtab[gidx], in_taken);
      ltab[lidx]    <= bump_c(ltab[lidx], in_taken);
      last_q[in_id] <= in_taken;
      hist_q        <= {hist_q[HIST_W-2:0], in_taken};
      if (glob_pred != loc_pred)
        sel_q[in_id] <= bump_s(sel_q[in_id], loc_pred == in_taken);
      if (final_pred != in_taken)
        miss_count <= miss_count + 1'b1;
    end
  end

endmodule

// File: rtl/tourney_pred_chk.sv
module tourney_pred_chk #(
  parameter int ID_W = 3,
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ID_W-1:0]   in_id,
  input logic              in_taken,
  input logic              glob_pred,
  input logic              loc_pred,
  input logic              sel_local,
  input logic              final_pred,
  input logic [MISS_W-1:0] miss_count
);

  AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> miss_count == '0); // R1

  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && final_pred != in_taken) |=> miss_count == $past(miss_count) + 1'b1); // R7

  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && final_pred != in_taken) |=> $stable(miss_count)); // R7

  AST_AGREE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_pred == loc_pred) |-> final_pred == glob_pred); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (in_id != $past(in_id)) ||
      (glob_pred == $past(glob_pred) && loc_pred == $past(loc_pred) &&
       sel_local == $past(sel_local))); // R8

endmodule

bind tourney_pred tourney_pred_chk #(.ID_W(ID_W), .MISS_W(MISS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id), .in_taken(in_taken),
  .glob_pred(glob_pred), .loc_pred(loc_pred), .sel_local(sel_local),
  .final_pred(final_pred), .miss_count(miss_count)
);

// File: tb/tourney_pred_tb_top.sv
`timescale 1ns/1ps
module tourney_pred_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_id = '0;
  logic in_taken = 1'b0;
  logic glob_pred, loc_pred, sel_local, final_pred;
  logic [15:0] miss_count;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tourney_pred dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id), .in_taken(in_taken),
    .glob_pred(glob_pred), .loc_pred(loc_pred), .sel_local(sel_local),
    .final_pred(final_pred), .miss_count(miss_count)
  );

  typedef struct {
    logic v; logic g; logic l; logic s; logic f; logic [15:0] m;
  } exp_t;
  exp_t q[$];

  logic [1:0] m_g [64];
  logic [1:0] m_l [16];
  logic [1:0] m_sel [8];
  logic [7:0] m_last;
  logic [1:0] m_hist;
  logic [15:0] m_miss;

  function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_g[i] = 2'b01;
    for (int i = 0; i < 16; i++) m_l[i] = 2'b01;
    for (int i = 0; i < 8; i++) m_sel[i] = 2'b01;
    m_last = '0; m_hist = '0; m_miss = '0;
  endtask

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] id, input logic tk);
    exp_t e;
    int gi, li;
    @(negedge clk);
    in_valid = v; in_id = id; in_taken = tk;
    gi = id * 4 + m_hist;
    li = id * 2 + m_last[id];
    e.v = v;
    e.g = m_g[gi][1];
    e.l = m_l[li][1];
    e.s = m_sel[id][1];
    e.f = e.s ? e.l : e.g;
    e.m = m_miss;
    q.push_back(e);
    if (v) begin
      m_g[gi] = sat(m_g[gi], tk);
      m_l[li] = sat(m_l[li], tk);
      if (e.g != e.l) m_sel[id] = sat(m_sel[id], e.l == tk);
      if (e.f != tk) m_miss++;
      m_last[id] = tk;
      m_hist = {m_hist[0], tk};
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.v ? "R2/R3" : "R8", "glob_pred", 16'(glob_pred), 16'(e.g));
      check(e.v ? "R4" : "R8", "loc_pred", 16'(loc_pred), 16'(e.l));
      check(e.v ? "R5" : "R8", "sel_local", 16'(sel_local), 16'(e.s));
      check("R6", "final_pred", 16'(final_pred), 16'(e.f));
      check("R7", "miss_count", miss_count, e.m);
    end
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1", "miss_count", miss_count, 16'd0);
    check("R1", "final_pred", 16'(final_pred), 16'd0);
    check("R1", "sel_local", 16'(sel_local), 16'd0);
    // R2: drive one branch taken repeatedly to saturate its counters, then reverse
    for (int i = 0; i < 8; i++) drive(1, 3'd2, 1);
    for (int i = 0; i < 8; i++) drive(1, 3'd2, 0);
    // loop-like branch: taken seven times then exits, repeated
    for (int r = 0; r < 6; r++)
      for (int i = 0; i < 8; i++) drive(1, 3'd0, i != 7);
    // R4: alternating branch favours the local side
    for (int i = 0; i < 24; i++) drive(1, 3'd1, i[0]);
    // R8: idle cycles between pairs, same and differing ids
    for (int i = 0; i < 10; i++) begin
      drive(0, 3'(i), ~i[0]);
      drive(1, 3'(i), i[1]);
      drive(0, 3'(i), i[0]);
    end
    // mixed pseudo-random trace over all ids
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[7:0] != 0, r[10:8], r[12] | r[13]);
    end
    drive(0, 3'd0, 0);
    repeat (3) @(negedge clk);
    #2;
    check("R7", "final miss_count", miss_count, m_miss);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule